// File: doc/BRIEF.md
# Circular Buffer Address Generator

This unit computes the next position inside a circular buffer in one clock cycle. In index mode, the position is an element index running from 0 to length-1. A signed step is added to the index. If the sum runs off either end of the buffer, it is folded back with a single correction of one buffer length.

In pointer mode, the position is a byte address in a buffer that starts at a base address. The step and the buffer length are both given in elements. The unit scales them to bytes by the element size (1, 2 or 4 bytes). It folds the byte offset from the base in the same way and adds the base back to form the result.

A request is presented with a one-cycle strobe, and every cycle may carry a new request. The result and an error flag are registered and appear one cycle later with a valid strobe. Between requests the result and the flag keep their last values. An error is flagged for any of three cases: a zero length, a step whose magnitude exceeds the length, or an unsupported element-size code.

Top module: `circ_addr_gen`

## Requirements
- R1: In index mode (`mode_i`=0), when 0 <= `pos_i`+`step_i` < `len_i`, the result is `pos_i`+`step_i`.
- R2: In index mode, when `pos_i`+`step_i` is negative, the result is that sum plus `len_i` (added once). A step of exactly -`len_i` is legal and raises no error.
- R3: In index mode, when `pos_i`+`step_i` >= `len_i`, the result is that sum minus `len_i` (subtracted once). A sum equal to `len_i` gives 0.
- R4: In pointer mode (`mode_i`=1), the step and the length are multiplied by the element size. The size codes on `esize_i` are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Code 3 is illegal: it sets the error flag, and the result equals `pos_i`.
- R5: In pointer mode, the wrap of R1 to R3 applies to the byte offset `pos_i`-`base_i`, measured against the scaled length. The result is `base_i` plus the folded offset.
- R6: When the step magnitude |`step_i`| exceeds `len_i`, the error flag is set, and the result is still the single-correction value of R1 to R3 (R5 in pointer mode). A magnitude equal to `len_i` is not an error.
- R7: When `len_i` is 0, the error flag is set. The result is `pos_i` in index mode and `base_i` in pointer mode.
- R8: `vld_o` is high exactly one cycle after each cycle in which `start_i` is high. `addr_o` and `err_o` change only in that cycle and otherwise hold their values.
- R9: While reset is asserted, `vld_o`, `addr_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one request per cycle |
| mode_i | input | 1 | 0 = index mode, 1 = pointer mode |
| esize_i | input | 2 | Element size code in pointer mode |
| pos_i | input | W | Current index or byte pointer |
| step_i | input | W | Signed step in elements |
| len_i | input | W | Buffer length in elements |
| base_i | input | W | Buffer base address (pointer mode) |
| vld_o | output | 1 | Result valid, one cycle after `start_i` |
| addr_o | output | W | Next index or pointer |
| err_o | output | 1 | Request broke a legality rule |

## Verification
On every cycle, the embedded assertions check the timing of the valid strobe and the holding of the outputs between requests. They also check that a zero length raises the flag and keeps the index, and that a legal index-mode request lands inside 0 to length-1. Only the bench's scenarios can show the exact folded values. These include the two boundaries, a sum equal to the length and a step of exactly minus the length. The bench also covers the byte scaling for each size code, the return to the base in pointer mode, and the result produced alongside an over-range step.

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [1:0]   esize_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] len_i,
  input  logic [W-1:0] base_i,
  output logic         vld_o,
  output logic [W-1:0] addr_o,
  output logic         err_o
);

  localparam int XW = W + 5;

  logic               bad_size, zero_len, over;
  logic [1:0]         sh;
  logic [W:0]         mag;
  logic [W-1:0]       off, folded_w, res;
  logic signed [XW-1:0] inc_x, len_x, sum, sum_p, sum_m, folded;

  assign bad_size = mode_i && (esize_i == 2'd3);
  assign zero_len = (len_i == '0);
  assign sh       = (mode_i && !bad_size) ? esize_i : 2'd0;

  assign mag  = step_i[W-1] ? ({1'b0, ~step_i} + {{W{1'b0}}, 1'b1}) : {1'b0, step_i};
  assign over = mag > {1'b0, len_i};

  assign inc_x = $signed({{5{step_i[W-1]}}, step_i}) <<< sh;
  assign len_x = $signed({5'b0, len_i} << sh);
  assign off   = mode_i ? (pos_i - base_i) : pos_i;

  assign sum   = $signed({5'b0, off}) + inc_x;
  assign sum_p = sum + len_x;
  assign sum_m = sum - len_x;

  assign folded   = (sum < 0) ? sum_p : ((sum >= len_x) ? sum_m : sum);
  assign folded_w = folded[W-1:0];

  assign res = bad_size ? pos_i :
               zero_len ? (mode_i ? base_i : pos_i) :
               (mode_i ? (base_i + folded_w) : folded_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      err_o  <= 1'b0;
    end else begin
      vld_o <= start_i;
      if (start_i) begin
        addr_o <= res;
        err_o  <= bad_size | zero_len | over;
      end
    end
  end

  AST_VLD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> vld_o); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!vld_o && $stable(addr_o) && $stable(err_o))); // R8
  AST_ZERO_LEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_i == '0) |=> err_o); // R7
  AST_ZERO_LEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !mode_i && len_i == '0) |=> (addr_o == $past(pos_i))); // R7
  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !mode_i && len_i != '0 && pos_i < len_i && !over)
      |=> (addr_o < $past(len_i) && !err_o)); // R3

endmodule

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [1:0] esz = 0;
  logic [W-1:0] pos = 0, step = 0, len = 0, base = 0;
  logic vld, err;
  logic [W-1:0] addr;

  int n_chk = 0, n_fail = 0;
  bit checking = 0;
  string tag = "R1";

  logic m_valid, m_err;
  logic [W-1:0] m_next;
  string m_tag;

  always #2 clk = ~clk;

  circ_addr_gen #(.W(W)) i_circ_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .esize_i(esz),
    .pos_i(pos), .step_i(step), .len_i(len), .base_i(base),
    .vld_o(vld), .addr_o(addr), .err_o(err));

  function automatic void model(input bit m, input logic [31:0] c, input logic [31:0] i,
                                input logic [31:0] l, input logic [31:0] b, input logic [1:0] e,
                                output logic [31:0] n, output logic er);
    longint ii, li, sc, off, s, lb, w;
    logic [31:0] d;
    bit bad;
    ii  = longint'($signed(i));
    li  = longint'(l);
    bad = m && (e == 2'd3);
    sc  = m ? (longint'(1) << e) : 1;
    er  = bad || (l == 0) || ((ii < 0 ? -ii : ii) > li);
    if (bad) n = c;
    else if (l == 0) n = m ? b : c;
    else begin
      d   = m ? (c - b) : c;
      off = longint'(d);
      s   = off + ii * sc;
      lb  = li * sc;
      w   = (s < 0) ? s + lb : ((s >= lb) ? s - lb : s);
      n   = m ? 32'(longint'(b) + w) : 32'(w);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0; m_next <= 0; m_err <= 0; m_tag <= "R9";
    end else begin
      logic [31:0] n; logic e;
      m_valid <= start;
      if (start) begin
        model(mode, pos, step, len, base, esz, n, e);
        m_next <= n; m_err <= e; m_tag <= tag;
      end else m_tag <= "R8";
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      n_chk++;
      if (vld !== m_valid || addr !== m_next || err !== m_err) begin
        n_fail++;
        $display("FAIL %s: vld=%0b addr=%h err=%0b expected vld=%0b addr=%h err=%0b",
                 m_tag, vld, addr, err, m_valid, m_next, m_err);
      end
    end
  end

  task automatic issue(input bit m, input logic [31:0] c, input logic [31:0] i,
                       input logic [31:0] l, input logic [31:0] b, input logic [1:0] e,
                       input string t);
    @(negedge clk);
    start = 1; mode = m; pos = c; step = i; len = l; base = b; esz = e; tag = t;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 0; pos = $urandom; step = $urandom; len = $urandom;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (vld !== 0 || addr !== 0 || err !== 0) begin
      n_fail++;
      $display("FAIL R9: vld=%0b addr=%h err=%0b expected 0 0 0", vld, addr, err);
    end
    rst_n = 1;
    checking = 1;
    idle(2);
    // index mode
    issue(0, 3, 2, 10, 0, 0, "R1");
    issue(0, 1, -3, 10, 0, 0, "R2");
    issue(0, 8, 4, 10, 0, 0, "R3");
    idle(1);
    issue(0, 9, 1, 10, 0, 0, "R3");
    issue(0, 0, -10, 10, 0, 0, "R2");
    issue(0, 2, 11, 10, 0, 0, "R6");
    idle(3);
    issue(0, 5, 1, 0, 0, 0, "R7");
    idle(2);
    // pointer mode
    issue(1, 32'h101C, 1, 8, 32'h1000, 2, "R5");
    issue(1, 32'h1000, -1, 8, 32'h1000, 1, "R4");
    issue(1, 32'h1003, 2, 8, 32'h1000, 0, "R4");
    issue(1, 32'h1008, 3, 4, 32'h1000, 1, "R5");
    issue(1, 32'h2004, 1, 0, 32'h2000, 2, "R7");
    issue(1, 32'h1004, 1, 8, 32'h1000, 3, "R4");
    issue(1, 32'h1004, -9, 8, 32'h1000, 2, "R6");
    idle(2);
    for (int k = 0; k < 60; k++) begin
      logic [31:0] l, c, s;
      l = ($urandom % 50) + 1;
      c = $urandom % l;
      s = 32'($signed(int'($urandom % (2 * l + 1)) - int'(l)));
      issue(k[0], k[0] ? c + 32'h4000 : c, s, l, 32'h4000, 2'(k % 3), "R1");
      if (k % 7 == 0) idle(1);
    end
    idle(3);
    checking = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule